// File: doc/BRIEF.md
# Fault Qualification Delay Timers

This block sits between raw protection comparator flags and the fault latch of an eight-channel half-bridge driver. It turns the raw flags into qualified fault events, and it does so only after each condition has lasted long enough. Each channel has its own over-current timer. One timer, shared by every channel, qualifies the low-side under-current (open-load) flags. A further timer qualifies the supply under-voltage flag and produces a supply-fail level.

Every delay is a parameter counted in clock cycles. Per-channel events are single-cycle pulses, and the fault latch downstream holds them. The block carries no data stream. All of its pins are plain control and status levels or pulses, with no valid/ready handshake and no back-pressure. The bench shortens the defaults, which are sized for a 250 MHz clock (about 25 µs, 350 µs and 14 ms).

Top module: `fault_qual_timers`

## Requirements
- R1: After reset, `oc_event` and `ol_event` are all zero and `supply_fail` is low.
- R2: When `oc_raw[i]` is sampled high on OC_CYCLES consecutive clock edges, `oc_event[i]` is high for one cycle, starting right after the OC_CYCLES-th edge.
- R3: An over-current episode yields exactly one pulse, however long the flag stays high. `oc_raw[i]` must fall and rise again before another pulse can occur.
- R4: If `oc_raw[i]` falls before the delay has elapsed, no event is produced and the channel timer returns to zero. The next episode needs the full OC_CYCLES again.
- R5: Over-current timers are independent per channel: bit i of `oc_event` depends only on `oc_raw[i]`.
- R6: A channel counts as pending for open-load only when `ls_undercur[i]`, `ch_en[i]` and `ls_on[i]` are all high. A channel that is not pending never produces an `ol_event` bit and does not start the shared timer.
- R7: The shared open-load timer starts with the first pending channel and expires OL_CYCLES edges later. At expiry, `ol_event` pulses for one cycle with a bit set for every channel pending at that edge, including channels that became pending after the timer started.
- R8: When no channel is pending at a clock edge, the shared timer returns to zero. A later pending condition waits the full OL_CYCLES.
- R9: While any channel stays pending, the shared timer keeps running and expires again every OL_CYCLES edges.
- R10: `supply_fail` rises right after the UV_CYCLES-th consecutive edge with `uv_raw` high, and it stays high while `uv_raw` stays high.
- R11: `supply_fail` falls in the same cycle that `uv_raw` falls, with no clock delay. A new under-voltage episode needs the full UV_CYCLES again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oc_raw | input | NUM_CH | Raw over-current comparator flags, one per channel |
| ch_en | input | NUM_CH | Channel enabled (not high impedance) |
| ls_on | input | NUM_CH | Low-side switch of the channel is driven on |
| ls_undercur | input | NUM_CH | Low-side current below open-load reference |
| uv_raw | input | 1 | Raw supply under-voltage comparator flag |
| oc_event | output | NUM_CH | Qualified over-current pulse per channel |
| ol_event | output | NUM_CH | Qualified open-load pulse per channel |
| supply_fail | output | 1 | Qualified supply-fail level |

## Verification
An over-current expiry and a shared open-load expiry can land on the same clock edge for the same channel. Both then have to reach the outputs in that one cycle. The bench provokes this by making channel 0 open-load pending first. It then raises that channel's over-current flag exactly OL_CYCLES − OC_CYCLES edges later. The check expects `oc_event[0]` and `ol_event[0]` high together in one sampled cycle, and neither of them one cycle before or after. A second collision comes from a late-joining channel: its open-load bit must appear at the very edge where the earlier channel's timer expires.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int unsigned FQ_NUM_CH    = 8;
  localparam int unsigned FQ_OC_CYCLES = 6250;
  localparam int unsigned FQ_OL_CYCLES = 87500;
  localparam int unsigned FQ_UV_CYCLES = 3500000;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/fq_oc_timer.sv
module fq_oc_timer #(
  parameter int unsigned OC_CYCLES = fq_pkg::FQ_OC_CYCLES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic evt
);
  localparam int unsigned W = fq_pkg::cnt_width(OC_CYCLES);
  localparam logic [W-1:0] LIMIT = W'(OC_CYCLES);
  localparam logic [W-1:0] LAST  = W'(OC_CYCLES - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      evt <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (!raw) begin
        cnt <= '0;
      end else if (cnt != LIMIT) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) evt <= 1'b1;
      end
    end
  end

  // R2: a qualified pulse needs the flag present on the qualifying edge
  a_r2_flag_behind_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(raw));
  // R3: one pulse per episode
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  // R4: a dropped flag leaves the timer at zero
  a_r4_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> (cnt == '0));
endmodule

// File: rtl/fq_ol_timer.sv
module fq_ol_timer #(
  parameter int unsigned NUM_CH    = fq_pkg::FQ_NUM_CH,
  parameter int unsigned OL_CYCLES = fq_pkg::FQ_OL_CYCLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] evt
);
  localparam int unsigned W = fq_pkg::cnt_width(OL_CYCLES);
  localparam logic [W-1:0] LAST = W'(OL_CYCLES - 1);

  logic [W-1:0] gcnt;
  logic         any_pend;

  assign any_pend = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcnt <= '0;
      evt  <= '0;
    end else begin
      evt <= '0;
      if (!any_pend) begin
        gcnt <= '0;
      end else if (gcnt == LAST) begin
        gcnt <= '0;
        evt  <= pend;
      end else begin
        gcnt <= gcnt + 1'b1;
      end
    end
  end

  // R6: only channels pending on the expiry edge are reported
  a_r6_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |-> ((evt & ~$past(pend)) == '0));
  // R8: an idle edge returns the shared timer to zero
  a_r8_idle_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> (gcnt == '0));
  // R7: expiry pulses last a single cycle
  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (evt == '0));
endmodule

// File: rtl/fq_uv_timer.sv
module fq_uv_timer #(
  parameter int unsigned UV_CYCLES = fq_pkg::FQ_UV_CYCLES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic fail
);
  localparam int unsigned W = fq_pkg::cnt_width(UV_CYCLES);
  localparam logic [W-1:0] LAST = W'(UV_CYCLES - 1);

  logic [W-1:0] cnt;
  logic         qual_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      qual_q <= 1'b0;
    end else if (!raw) begin
      cnt    <= '0;
      qual_q <= 1'b0;
    end else if (!qual_q) begin
      if (cnt == LAST) qual_q <= 1'b1;
      else             cnt    <= cnt + 1'b1;
    end
  end

  // Release path is combinational so recovery costs no cycle.
  assign fail = qual_q & raw;

  // R10: assertion only after the flag was already present
  a_r10_rise_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(raw));
  // R11: a cleared flag re-arms the count from zero
  a_r11_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> (cnt == '0 && !qual_q));
endmodule

// File: rtl/fault_qual_timers.sv
module fault_qual_timers #(
  parameter int unsigned NUM_CH    = fq_pkg::FQ_NUM_CH,
  parameter int unsigned OC_CYCLES = fq_pkg::FQ_OC_CYCLES,
  parameter int unsigned OL_CYCLES = fq_pkg::FQ_OL_CYCLES,
  parameter int unsigned UV_CYCLES = fq_pkg::FQ_UV_CYCLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] oc_raw,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ls_on,
  input  logic [NUM_CH-1:0] ls_undercur,
  input  logic              uv_raw,
  output logic [NUM_CH-1:0] oc_event,
  output logic [NUM_CH-1:0] ol_event,
  output logic              supply_fail
);
  logic [NUM_CH-1:0] ol_pend;

  // R6: open-load only observed on an enabled channel with its low side driven
  assign ol_pend = ls_undercur & ch_en & ls_on;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_oc
    fq_oc_timer #(.OC_CYCLES(OC_CYCLES)) u_oc (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (oc_raw[g]),
      .evt  (oc_event[g])
    );
  end

  fq_ol_timer #(.NUM_CH(NUM_CH), .OL_CYCLES(OL_CYCLES)) u_ol (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (ol_pend),
    .evt  (ol_event)
  );

  fq_uv_timer #(.UV_CYCLES(UV_CYCLES)) u_uv (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (uv_raw),
    .fail (supply_fail)
  );

  // R5: an over-current pulse always traces back to its own channel's flag
  a_r5_own_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_event) |-> ((oc_event & ~$past(oc_raw)) == '0));
endmodule

// File: tb/test_fault_qual_timers.sv
module test_fault_qual_timers;
  localparam int unsigned N  = 8;
  localparam int unsigned OC = 6;
  localparam int unsigned OL = 16;
  localparam int unsigned UV = 24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] oc_raw, ch_en, ls_on, ls_undercur;
  logic         uv_raw;
  logic [N-1:0] oc_event, ol_event;
  logic         supply_fail;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fault_qual_timers #(.NUM_CH(N), .OC_CYCLES(OC), .OL_CYCLES(OL), .UV_CYCLES(UV)) i_fault_qual_timers (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .ch_en(ch_en), .ls_on(ls_on),
    .ls_undercur(ls_undercur), .uv_raw(uv_raw), .oc_event(oc_event),
    .ol_event(ol_event), .supply_fail(supply_fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    oc_raw = '0; ls_undercur = '0; uv_raw = 1'b0;
    ch_en = '1; ls_on = '1;
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic t_reset();
    chk(oc_event == '0, "R1 oc", oc_event, 0);
    chk(ol_event == '0, "R1 ol", ol_event, 0);
    chk(supply_fail == 1'b0, "R1 fail", supply_fail, 0);
  endtask

  task automatic t_oc_basic();
    oc_raw[2] = 1'b1;
    for (int k = 1; k <= OC; k++) begin
      tick();
      chk(oc_event == ((k == OC) ? 8'h04 : 8'h00), "R2 delay", oc_event, (k == OC) ? 4 : 0);
    end
    for (int k = 0; k < 8; k++) begin
      tick();
      chk(oc_event == '0, "R3 one pulse", oc_event, 0);
    end
    idle(2);
  endtask

  task automatic t_oc_glitch();
    oc_raw[1] = 1'b1;
    for (int k = 1; k < OC; k++) begin
      tick();
      chk(oc_event == '0, "R4 early", oc_event, 0);
    end
    oc_raw[1] = 1'b0;
    tick();
    chk(oc_event == '0, "R4 dropped", oc_event, 0);
    oc_raw[1] = 1'b1;
    for (int k = 1; k <= OC; k++) begin
      tick();
      chk(oc_event == ((k == OC) ? 8'h02 : 8'h00), "R4 restart full", oc_event, (k == OC) ? 2 : 0);
    end
    idle(2);
  endtask

  task automatic t_oc_independent();
    oc_raw[0] = 1'b1;
    for (int t = 1; t <= OC + 4; t++) begin
      tick();
      if (t == 2) oc_raw[5] = 1'b1;
      chk(oc_event == (((t == OC) ? 8'h01 : 8'h00) | ((t == OC + 2) ? 8'h20 : 8'h00)),
          "R5 independent", oc_event, t);
    end
    idle(2);
  endtask

  task automatic t_ol_gating();
    ch_en[1] = 1'b0; ls_undercur[1] = 1'b1;
    ls_on[2] = 1'b0; ls_undercur[2] = 1'b1;
    for (int k = 0; k < OL + 3; k++) begin
      tick();
      chk(ol_event == '0, "R6 gated", ol_event, 0);
    end
    ch_en[1] = 1'b1;
    for (int t = 1; t <= OL + 1; t++) begin
      tick();
      chk(ol_event == ((t == OL) ? 8'h02 : 8'h00), "R6 enable starts timer", ol_event, (t == OL) ? 2 : 0);
    end
    idle(2);
  endtask

  task automatic t_ol_late_join();
    ls_undercur[3] = 1'b1;
    for (int t = 1; t <= OL + 1; t++) begin
      tick();
      if (t == 10) ls_undercur[6] = 1'b1;
      chk(ol_event == ((t == OL) ? 8'h48 : 8'h00), "R7 late joiner", ol_event, (t == OL) ? 8'h48 : 0);
    end
    idle(2);
  endtask

  task automatic t_ol_idle_reset();
    ls_undercur[4] = 1'b1;
    for (int k = 0; k < 10; k++) tick();
    ls_undercur[4] = 1'b0;
    tick();
    ls_undercur[4] = 1'b1;
    for (int t = 1; t <= OL; t++) begin
      tick();
      chk(ol_event == ((t == OL) ? 8'h10 : 8'h00), "R8 full restart", ol_event, (t == OL) ? 8'h10 : 0);
    end
    idle(2);
  endtask

  task automatic t_ol_repeat();
    ls_undercur[3] = 1'b1;
    ls_undercur[6] = 1'b1;
    for (int t = 1; t <= 2 * OL + 1; t++) begin
      tick();
      if (t == OL) ls_undercur[6] = 1'b0;
      chk(ol_event == ((t == OL) ? 8'h48 : (t == 2 * OL) ? 8'h08 : 8'h00),
          "R9 periodic", ol_event, t);
    end
    idle(2);
  endtask

  task automatic t_uv();
    uv_raw = 1'b1;
    for (int k = 1; k <= UV + 3; k++) begin
      tick();
      chk(supply_fail == (k >= UV), "R10 qualify", supply_fail, (k >= UV) ? 1 : 0);
    end
    uv_raw = 1'b0;
    #1;
    chk(supply_fail == 1'b0, "R11 immediate release", supply_fail, 0);
    tick();
    uv_raw = 1'b1;
    for (int k = 1; k <= UV; k++) begin
      tick();
      chk(supply_fail == (k == UV), "R11 re-qualify", supply_fail, (k == UV) ? 1 : 0);
    end
    idle(2);
  endtask

  task automatic t_collide();
    ls_undercur[0] = 1'b1;
    for (int t = 1; t <= OL + 1; t++) begin
      tick();
      if (t == OL - OC) oc_raw[0] = 1'b1;
      chk({oc_event[0], ol_event[0]} == ((t == OL) ? 2'b11 : 2'b00),
          "R2 R7 same edge", {oc_event[0], ol_event[0]}, (t == OL) ? 3 : 0);
    end
    idle(2);
  endtask

  initial begin
    rst_n = 1'b0;
    oc_raw = '0; ls_undercur = '0; uv_raw = 1'b0; ch_en = '1; ls_on = '1;
    repeat (3) @(negedge clk);
    tick();
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_oc_basic();
    t_oc_glitch();
    t_oc_independent();
    t_ol_gating();
    t_ol_late_join();
    t_ol_idle_reset();
    t_ol_repeat();
    t_uv();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule